// File: doc/BRIEF.md
# DTMF Transceiver Register Interface

This block is the processor-facing register file of a DTMF transceiver. A host reaches it over a narrow four-bit bus made of a chip select, one register-select line, a read/write line and a bus strobe. Writes go either to a transmit code register or to a pair of control registers that share one address. Reads return either the last received tone code or a status word. The bus is split into input data, output data and an output-enable, so a pad ring can build the bidirectional pins from them.

On the inside, the block takes events from the tone receiver and the tone generator:
- a pulse that carries a newly registered receive code;
- the level that says a valid tone is being held;
- a pulse when a burst and its pause have finished.

It passes the decoded control bits on to the generator and the steering logic. It also drives one active-low interrupt pin. Depending on mode, that pin carries:
- the interrupt request;
- the call-progress square wave;
- the steering level, for test.

All logic runs on one system clock. The strobe and bus lines are sampled on that clock, and every register update happens in the clock cycle in which the strobe is seen to fall. There is no valid/ready handshake here. Every interface is a plain level or a one-cycle pulse, and the host paces itself through the strobe.

Top module: `dtmf_bus_regs`

## Requirements
- R1: A bus cycle with rs=0 and rw=0 stores d_in as the transmit code. tx_code shows the new value, and tx_load is high for exactly one cycle after the cycle in which the strobe falls.
- R2: An rx_valid pulse latches rx_code into the receive register, which is read with rs=0 and rw=1. While call-progress mode is on, rx_valid is ignored: neither the register nor the status word changes.
- R3: A control write (rs=1, rw=0) that is not armed goes to register A. In A, bit 2 is interrupt enable, bit 1 is call-progress mode (1 = call progress) and bit 0 is tone enable (output tone_en). Bit 3 arms the register-B pointer.
- R4: After an A write with bit 3 set, only the next control write goes to register B. In B, bit 3 is column select (col_sel), bit 2 is single tone (single_tone), bit 1 is test mode (test_mode) and bit 0 is burst-off, so burst_on = ~bit0. Every later control write goes to A again, and an A write leaves B unchanged.
- R5: A status read (rs=1, rw=1) returns the following bits:
  - bit 0: interrupt pending;
  - bit 1: transmitter ready;
  - bit 2: receive register full;
  - bit 3: the inverse of tone_held.
- R6: Status bits 0..2 clear at the end of a status read, when the strobe falls. An event that arrives in that same clock cycle takes priority over the clear, so its flag stays set.
- R7: tx_done sets status bit 1 only while burst_on is high. While burst_on is low, bit 1 is held clear and tx_done does nothing.
- R8: Status bit 0 is set whenever bit 1 or bit 2 becomes set.
- R9: When interrupt enable is on, call-progress mode is off and test mode is off, irq_n equals the inverse of status bit 0. When interrupt enable is off and test mode is off, irq_n is 1.
- R10: When test mode is on and call-progress mode is off, irq_n follows tone_held. This holds whatever the interrupt enable is.
- R11: When call-progress mode and interrupt enable are both on, irq_n follows cp_wave.
- R12: d_oe is high only while cs_n=0, strobe=1 and rw=1 all hold at once.
- R13: A synchronous reset clears both control registers, the transmit code, the receive register and the status flags, and disarms the B pointer. After reset, burst_on is 1 and the first control write goes to A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select |
| rw | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | Bus strobe; access ends on its falling edge |
| d_in | input | 4 | Write data from the bus |
| d_out | output | 4 | Read data to the bus |
| d_oe | output | 1 | Bus output enable |
| rx_valid | input | 1 | One-cycle pulse: new receive code |
| rx_code | input | 4 | Receive code carried with rx_valid |
| tone_held | input | 1 | Level: valid tone registered by steering |
| tx_done | input | 1 | One-cycle pulse: burst and pause finished |
| cp_wave | input | 1 | Limited call-progress square wave |
| tx_code | output | 4 | Transmit code to the generator |
| tx_load | output | 1 | One-cycle pulse: new transmit code |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode selected |
| burst_on | output | 1 | Burst timing enabled |
| single_tone | output | 1 | Single tone instead of a tone pair |
| col_sel | output | 1 | Single tone taken from the column group |
| test_mode | output | 1 | Test mode bit |
| irq_n | output | 1 | Interrupt / call-progress / test pin |

## Verification
The assertions assume that each host access keeps cs_n, rs, rw and d_in steady from the cycle the strobe rises until the cycle after it falls. They also assume that rx_valid and tx_done are single-cycle pulses. The bench keeps to this: every access task drives its lines at the inactive clock edge, holds them through the strobe, and releases chip select only after the strobe is low. Event pulses are raised for exactly one cycle. One of them is placed on purpose in the cycle where a status read ends, so that the priority of a set over the clear is exercised.

// File: rtl/dtmfx_pkg.sv
package dtmfx_pkg;
  localparam int DW = 4;

  // access kind, encoded as {rs, rw}
  typedef enum logic [1:0] {
    ACC_TXD = 2'b00,
    ACC_RXD = 2'b01,
    ACC_CTL = 2'b10,
    ACC_STS = 2'b11
  } acc_e;

  typedef struct packed {
    logic irq_en;
    logic cp_mode;
    logic tone_en;
  } cra_t;

  typedef struct packed {
    logic col_sel;
    logic single;
    logic test;
    logic burst_n;
  } crb_t;
endpackage

// File: rtl/tbus_cap.sv
module tbus_cap
  import dtmfx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          rw,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic          wr_stb,
  output logic          rd_end,
  output acc_e          acc,
  output logic [DW-1:0] wdata
);
  logic str_q, sel_q;
  acc_e acc_q;
  logic [DW-1:0] wd_q;

  // capture the access while the strobe is high, act when it falls
  always_ff @(posedge clk) begin
    if (rst) begin
      str_q <= 1'b0;
      sel_q <= 1'b0;
      acc_q <= ACC_TXD;
      wd_q  <= '0;
    end else begin
      str_q <= strobe;
      if (strobe) begin
        sel_q <= ~cs_n;
        acc_q <= acc_e'({rs, rw});
        wd_q  <= din;
      end
    end
  end

  logic end_cyc;
  assign end_cyc = str_q & ~strobe & sel_q;
  assign wr_stb  = end_cyc & ~acc_q[0];
  assign rd_end  = end_cyc &  acc_q[0];
  assign acc     = acc_q;
  assign wdata   = wd_q;
endmodule

// File: rtl/tctl_regs.sv
module tctl_regs
  import dtmfx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  acc_e          acc,
  input  logic [DW-1:0] wdata,
  output cra_t          cra,
  output crb_t          crb,
  output logic          arm,
  output logic [DW-1:0] tx_code,
  output logic          tx_load
);
  logic ctl_wr, txd_wr;
  assign ctl_wr = wr_stb & (acc == ACC_CTL);
  assign txd_wr = wr_stb & (acc == ACC_TXD);

  always_ff @(posedge clk) begin
    if (rst) begin
      cra     <= '0;
      crb     <= '0;
      arm     <= 1'b0;
      tx_code <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= txd_wr;
      if (txd_wr) tx_code <= wdata;
      if (ctl_wr) begin
        if (arm) begin
          crb <= crb_t'(wdata);
          arm <= 1'b0;
        end else begin
          cra <= cra_t'(wdata[DW-2:0]);
          arm <= wdata[DW-1];
        end
      end
    end
  end
endmodule

// File: rtl/tstat_flags.sv
module tstat_flags
  import dtmfx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  input  logic          tx_done,
  input  logic          cp_mode,
  input  logic          burst_on,
  input  logic          rd_sts,
  output logic [DW-1:0] rx_data,
  output logic          irqf,
  output logic          txe,
  output logic          rxf
);
  logic rx_ok, tx_ok;
  assign rx_ok = rx_valid & ~cp_mode;
  assign tx_ok = tx_done & burst_on;

  // a set in the same cycle as the read clear wins
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      irqf    <= 1'b0;
      txe     <= 1'b0;
      rxf     <= 1'b0;
    end else begin
      if (rx_ok) rx_data <= rx_code;
      rxf  <= rx_ok | (rxf & ~rd_sts);
      txe  <= burst_on & (tx_ok | (txe & ~rd_sts));
      irqf <= rx_ok | tx_ok | (irqf & ~rd_sts);
    end
  end
endmodule

// File: rtl/dtmf_bus_regs.sv
module dtmf_bus_regs
  import dtmfx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          rw,
  input  logic          strobe,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  input  logic          tone_held,
  input  logic          tx_done,
  input  logic          cp_wave,
  output logic [DW-1:0] tx_code,
  output logic          tx_load,
  output logic          tone_en,
  output logic          cp_mode,
  output logic          burst_on,
  output logic          single_tone,
  output logic          col_sel,
  output logic          test_mode,
  output logic          irq_n
);
  logic          wr_stb, rd_end;
  acc_e          acc;
  logic [DW-1:0] wdata;
  cra_t          cra;
  crb_t          crb;
  logic          arm_w;
  logic [DW-1:0] rx_data;
  logic          irqf, txe, rxf;
  logic [DW-1:0] status_w;
  logic          rd_sts_w, ctl_wr_w;

  tbus_cap u_cap (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rs(rs), .rw(rw), .strobe(strobe),
    .din(d_in), .wr_stb(wr_stb), .rd_end(rd_end), .acc(acc), .wdata(wdata)
  );

  tctl_regs u_ctl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .acc(acc), .wdata(wdata),
    .cra(cra), .crb(crb), .arm(arm_w), .tx_code(tx_code), .tx_load(tx_load)
  );

  assign rd_sts_w = rd_end & (acc == ACC_STS);
  assign ctl_wr_w = wr_stb & (acc == ACC_CTL);

  tstat_flags u_sts (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_code(rx_code),
    .tx_done(tx_done), .cp_mode(cra.cp_mode), .burst_on(burst_on),
    .rd_sts(rd_sts_w), .rx_data(rx_data), .irqf(irqf), .txe(txe), .rxf(rxf)
  );

  assign tone_en     = cra.tone_en;
  assign cp_mode     = cra.cp_mode;
  assign burst_on    = ~crb.burst_n;
  assign single_tone = crb.single;
  assign col_sel     = crb.col_sel;
  assign test_mode   = crb.test;

  assign status_w = {~tone_held, rxf, txe, irqf};
  assign d_oe     = ~cs_n & strobe & rw;
  assign d_out    = rs ? status_w : rx_data;

  always_comb begin
    if (crb.test && !cra.cp_mode)      irq_n = tone_held;
    else if (cra.cp_mode && cra.irq_en) irq_n = cp_wave;
    else if (cra.irq_en)               irq_n = ~irqf;
    else                               irq_n = 1'b1;
  end
endmodule

// File: rtl/dtmf_bus_chk.sv
module dtmf_bus_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       strobe,
  input logic       rw,
  input logic       d_oe,
  input logic       irq_n,
  input logic       tone_held,
  input logic       cp_wave,
  input logic       cp_mode,
  input logic       test_mode,
  input logic       burst_on,
  input logic       rx_valid,
  input logic       tx_done,
  input logic [3:0] status,
  input logic       arm,
  input logic       ctl_wr,
  input logic       rd_sts
);
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !strobe || !rw) |-> !d_oe); // R12
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_sts && !rx_valid && !tx_done) |=> (status[2:0] == 3'b000)); // R6
  AST_NOBURST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !burst_on |=> !status[1]); // R7
  AST_ARM_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && arm) |=> !arm); // R4
  AST_PEND_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    (status[1] || status[2]) |-> status[0]); // R8
  AST_TEST_PIN: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !cp_mode) |-> (irq_n == tone_held)); // R10
endmodule

bind dtmf_bus_regs dtmf_bus_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .strobe(strobe), .rw(rw), .d_oe(d_oe),
  .irq_n(irq_n), .tone_held(tone_held), .cp_wave(cp_wave), .cp_mode(cp_mode),
  .test_mode(test_mode), .burst_on(burst_on), .rx_valid(rx_valid),
  .tx_done(tx_done), .status(status_w), .arm(arm_w), .ctl_wr(ctl_wr_w),
  .rd_sts(rd_sts_w)
);

// File: tb/sim_dtmf_bus_regs.sv
module sim_dtmf_bus_regs;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rs = 1'b0, rw = 1'b0, strobe = 1'b0;
  logic [3:0] d_in = '0, rx_code = '0;
  logic rx_valid = 1'b0, tone_held = 1'b0, tx_done = 1'b0, cp_wave = 1'b0;
  logic [3:0] d_out, tx_code;
  logic d_oe, tx_load, tone_en, cp_mode, burst_on, single_tone, col_sel, test_mode, irq_n;
  int checks = 0, errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  dtmf_bus_regs u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rs(rs), .rw(rw), .strobe(strobe),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .rx_valid(rx_valid),
    .rx_code(rx_code), .tone_held(tone_held), .tx_done(tx_done),
    .cp_wave(cp_wave), .tx_code(tx_code), .tx_load(tx_load),
    .tone_en(tone_en), .cp_mode(cp_mode), .burst_on(burst_on),
    .single_tone(single_tone), .col_sel(col_sel), .test_mode(test_mode),
    .irq_n(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic r, input logic [3:0] v);
    @(negedge clk); cs_n = 1'b0; rs = r; rw = 1'b0; d_in = v; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  // race=1 raises rx_valid in the cycle where the read ends
  task automatic rd(input logic r, input logic race, output logic [3:0] v);
    @(negedge clk); cs_n = 1'b0; rs = r; rw = 1'b1; strobe = 1'b1;
    #1 v = d_out;
    check("R12 oe during read", d_oe, 1);
    @(negedge clk); strobe = 1'b0;
    if (race) begin rx_valid = 1'b1; rx_code = 4'hC; end
    @(negedge clk); cs_n = 1'b1; rw = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic pulse_rx(input logic [3:0] c);
    @(negedge clk); rx_valid = 1'b1; rx_code = c;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [3:0] v;
    @(negedge clk);
    check("R13 tx_code", tx_code, 0);
    check("R13 burst_on", burst_on, 1);
    check("R13 tone_en/cp/test", {tone_en, cp_mode, test_mode, single_tone, col_sel}, 0);
    check("R13 irq_n", irq_n, 1);
    check("R12 idle oe", d_oe, 0);
    rd(1'b1, 1'b0, v);
    check("R13 R5 status", v, 4'b1000);
    rd(1'b0, 1'b0, v);
    check("R13 rx data", v, 0);
  endtask

  task automatic t_tx();
    wr(1'b0, 4'h7);
    check("R1 tx_code", tx_code, 7);
    check("R1 tx_load pulse", tx_load, 1);
    @(negedge clk);
    check("R1 tx_load single", tx_load, 0);
    wr(1'b0, 4'h0);
    check("R1 tx_code zero digit", tx_code, 0);
  endtask

  task automatic t_ctrl();
    wr(1'b1, 4'b1011);
    check("R3 tone_en", tone_en, 1);
    check("R3 cp_mode", cp_mode, 1);
    check("R4 B untouched", {col_sel, single_tone, test_mode}, 0);
    wr(1'b1, 4'b1110);
    check("R4 B fields", {col_sel, single_tone, test_mode, burst_on}, 4'b1111);
    check("R4 A kept", {tone_en, cp_mode}, 2'b11);
    wr(1'b1, 4'b0101);
    check("R4 back to A", {tone_en, cp_mode}, 2'b10);
    check("R4 B kept", col_sel, 1);
    // reset while armed
    wr(1'b1, 4'b1000);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    wr(1'b1, 4'b0001);
    check("R13 disarmed", {tone_en, col_sel, single_tone, test_mode}, 4'b1000);
  endtask

  task automatic t_rx();
    logic [3:0] v;
    wr(1'b1, 4'b0000);
    tone_held = 1'b1;
    pulse_rx(4'h9);
    rd(1'b1, 1'b0, v);
    check("R5 R8 status rx", v, 4'b0101);
    rd(1'b0, 1'b0, v);
    check("R2 rx data", v, 4'h9);
    rd(1'b1, 1'b0, v);
    check("R6 cleared", v, 4'b0000);
    tone_held = 1'b0;
    wr(1'b1, 4'b0010);
    pulse_rx(4'h3);
    rd(1'b0, 1'b0, v);
    check("R2 cp ignores data", v, 4'h9);
    rd(1'b1, 1'b0, v);
    check("R2 cp no flag", v, 4'b1000);
  endtask

  task automatic t_race();
    logic [3:0] v;
    wr(1'b1, 4'b0000);
    pulse_rx(4'h1);
    rd(1'b1, 1'b1, v);
    check("R6 before race", v, 4'b1101);
    rd(1'b1, 1'b0, v);
    check("R6 set wins clear", v, 4'b1101);
    rd(1'b0, 1'b0, v);
    check("R6 race data", v, 4'hC);
    rd(1'b1, 1'b0, v);
    check("R6 cleared after", v, 4'b1000);
  endtask

  task automatic t_burst();
    logic [3:0] v;
    wr(1'b1, 4'b1100);
    wr(1'b1, 4'b0000);
    check("R9 idle irq", irq_n, 1);
    pulse_tx();
    check("R9 irq low", irq_n, 0);
    rd(1'b1, 1'b0, v);
    check("R7 R8 ready", v, 4'b1011);
    check("R9 irq released", irq_n, 1);
    wr(1'b1, 4'b1100);
    wr(1'b1, 4'b0001);
    pulse_tx();
    rd(1'b1, 1'b0, v);
    check("R7 nonburst ignored", v, 4'b1000);
    check("R7 irq stays", irq_n, 1);
  endtask

  task automatic t_pins();
    wr(1'b1, 4'b1000);
    wr(1'b1, 4'b0010);
    tone_held = 1'b1; #1;
    check("R10 test pin hi", irq_n, 1);
    tone_held = 1'b0; #1;
    check("R10 test pin lo", irq_n, 0);
    wr(1'b1, 4'b0110);
    cp_wave = 1'b1; #1;
    check("R11 cp pin hi", irq_n, 1);
    cp_wave = 1'b0; #1;
    check("R11 cp pin lo", irq_n, 0);
    wr(1'b1, 4'b1000);
    wr(1'b1, 4'b0000);
    pulse_rx(4'h5);
    check("R9 disabled pin", irq_n, 1);
    wr(1'b1, 4'b0100);
    check("R9 enabled pending", irq_n, 0);
  endtask

  task automatic t_bus();
    @(negedge clk); cs_n = 1'b1; rw = 1'b1; strobe = 1'b1; #1;
    check("R12 no cs", d_oe, 0);
    cs_n = 1'b0; strobe = 1'b0; #1;
    check("R12 strobe low", d_oe, 0);
    strobe = 1'b1; rw = 1'b0; #1;
    check("R12 write", d_oe, 0);
    @(negedge clk); cs_n = 1'b1; strobe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx();
    t_ctrl();
    t_rx();
    t_race();
    t_burst();
    t_pins();
    t_bus();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule